// File: doc/BRIEF.md
# Chained Interrupt-Driven Transfer Engine

This block moves one data item between two memory addresses each time an interrupt source activates it. It keeps its transfer descriptors in a small internal store. Each descriptor has two mode bytes, a source address, a destination address and a transfer count. When activation request `k` arrives, the engine fetches descriptor `k`. It reads one byte or word at the source address and writes that item at the destination address. It then writes the descriptor back with its addresses and count updated.

After the write-back, the engine decides what happens next. If chaining is set, it moves straight on to the following descriptor, and nothing is signalled to the interrupt logic. Otherwise it finishes. On finishing it does exactly one of three things: it asks the interrupt controller to clear the activating flag, it passes the interrupt to the CPU, or, when the count has run out, it asks for the source's activation enable to be cleared and also passes the interrupt. Repeat and block areas are reduced to a single choice of which side advances. The area side steps by the item size, and the other side stays on a fixed address.

Descriptors are loaded and read back through a plain configuration port. The memory port has no stalls: read data returns in the cycle after the read request.

Top module: `xfer_chain_ctrl`

## Requirements
- R1: After reset, `busy`, `mem_req`, `flag_clr`, `en_clr` and `cpu_irq` are all low.
- R2: An `act_req` is accepted only while `busy` is low, and it starts descriptor `act_idx`. Each descriptor processed keeps `busy` high for exactly 4 cycles: fetch, read, write and write-back. A request raised while `busy` is high is ignored.
- R3: Every transfer reads at the descriptor's source address and then, in the next cycle, writes the returned data to the destination address. If mode A bit 0 is 0, the transfer is a byte: `mem_word` is low and the written data is the low 8 bits with the upper byte zero. If bit 0 is 1, the transfer is a word: `mem_word` is high and all 16 bits are written.
- R4: Mode A bit 1 selects the advancing side. If it is 0, the destination address advances and the source address is unchanged. If it is 1, the source address advances and the destination address is unchanged. The step is 1 for a byte and 2 for a word.
- R5: The count is decremented by 1. The updated descriptor is written back to the same slot. The slot layout is {count[63:48], destination[47:32], source[31:16], mode B[15:8], mode A[7:0]}.
- R6: If mode B bit 7 (chain) is 1, the next descriptor (index + 1, wrapping to 0) is processed within the same activation. In that case no `flag_clr`, `en_clr` or `cpu_irq` pulse occurs, whatever the count is.
- R7: If chain is 0 and the updated count is 0, `en_clr` and `cpu_irq` each pulse once, `flag_clr` stays low, and the engine returns to idle.
- R8: If chain is 0, the updated count is nonzero and mode B bit 6 (interrupt select) is 0, only `flag_clr` pulses.
- R9: If chain is 0, the updated count is nonzero and interrupt select is 1, only `cpu_irq` pulses, and the activating flag is left set.
- R10: Mode B bits 5:0 and mode A bits 7:2 have no effect on addresses, data, counts or pulses.
- R11: `done_src` holds the index of the request that started the chain throughout the activation, including any pulses at the end of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| act_req | input | 1 | Activation request |
| act_idx | input | IDXW | Activating source, which is also its first descriptor index |
| busy | output | 1 | High while a chain is in progress |
| done_src | output | IDXW | Source of the current activation |
| flag_clr | output | 1 | Pulse: clear the activating interrupt flag |
| en_clr | output | 1 | Pulse: clear the source's activation enable |
| cpu_irq | output | 1 | Pulse: interrupt passed to the CPU |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_word | output | 1 | Word (1) or byte (0) access |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after a read |
| cfg_we | input | 1 | Descriptor store write |
| cfg_idx | input | IDXW | Descriptor index to write |
| cfg_wdata | input | 64 | Descriptor contents |
| rd_idx | input | IDXW | Descriptor index to read back |
| rd_data | output | 64 | Descriptor contents read back |

## Verification
Directed runs cover one descriptor under each of the three finishing outcomes, with the cases chosen so that clearing the flag, passing the interrupt and clearing the enable can each be told apart from the others. Further directed runs cover a three-descriptor chain that wraps from index 7 to 0 with counts reaching zero, which separates chain behaviour from end-of-count handling. Other directed runs set every reserved mode bit, and raise a second request mid-run to confirm that it is ignored. Random runs mix byte and word sizes, both advancing sides, both interrupt-select values and chain lengths of one to three. Each random run is compared against a bench model of addresses, data, write-back contents, pulse counts and busy length.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int DW = 16;

  localparam int SZ_BIT    = 0;
  localparam int SIDE_BIT  = 1;
  localparam int ISEL_BIT  = 6;
  localparam int CHAIN_BIT = 7;

  typedef struct packed {
    logic [CW-1:0] cnt;
    logic [AW-1:0] dst;
    logic [AW-1:0] src;
    logic [7:0]    mode_b;
    logic [7:0]    mode_a;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RD, S_WR, S_WB} st_t;

  function automatic logic [AW-1:0] addr_step(input logic word);
    return word ? AW'(2) : AW'(1);
  endfunction

  function automatic logic [DW-1:0] size_mask(input logic word, input logic [DW-1:0] d);
    return word ? d : {{(DW-8){1'b0}}, d[7:0]};
  endfunction

  function automatic desc_t desc_advance(input desc_t d);
    desc_t n;
    logic [AW-1:0] st;
    n  = d;
    st = addr_step(d.mode_a[SZ_BIT]);
    if (d.mode_a[SIDE_BIT]) n.src = d.src + st;
    else                    n.dst = d.dst + st;
    n.cnt = d.cnt - CW'(1);
    return n;
  endfunction
endpackage

// File: rtl/xfc_desc_mem.sv
module xfc_desc_mem
  import xfc_pkg::*;
#(
  parameter int NDESC = 8,
  localparam int IDXW = $clog2(NDESC)
) (
  input  logic            clk,
  input  logic            cfg_we,
  input  logic [IDXW-1:0] cfg_idx,
  input  desc_t           cfg_data,
  input  logic            eng_we,
  input  logic [IDXW-1:0] eng_idx,
  input  desc_t           eng_data,
  input  logic [IDXW-1:0] fetch_idx,
  output desc_t           fetch_data,
  input  logic [IDXW-1:0] rd_idx,
  output desc_t           rd_data
);
  desc_t slots [NDESC];

  // engine write-back wins over a configuration write in the same cycle
  always_ff @(posedge clk) begin
    if (eng_we)      slots[eng_idx] <= eng_data;
    else if (cfg_we) slots[cfg_idx] <= cfg_data;
  end

  assign fetch_data = slots[fetch_idx];
  assign rd_data    = slots[rd_idx];
endmodule

// File: rtl/xfc_finish.sv
module xfc_finish (
  input  logic clk,
  input  logic rst_n,
  input  logic wb_fire,
  input  logic chain,
  input  logic isel,
  input  logic cnt_zero,
  output logic chain_go,
  output logic flag_clr,
  output logic en_clr,
  output logic cpu_irq
);
  logic last_one;

  assign chain_go = wb_fire & chain;
  assign last_one = wb_fire & ~chain;
  assign en_clr   = last_one & cnt_zero;
  assign cpu_irq  = last_one & (cnt_zero | isel);
  assign flag_clr = last_one & ~cnt_zero & ~isel;

  assert_chain_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chain_go |-> !(flag_clr || en_clr || cpu_irq));
  assert_one_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_clr, cpu_irq}));
  assert_end_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr |-> (cpu_irq && !flag_clr));
  assert_pulse_at_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr || cpu_irq) |-> wb_fire);
endmodule

// File: rtl/xfc_seq.sv
module xfc_seq
  import xfc_pkg::*;
#(
  parameter int NDESC = 8,
  localparam int IDXW = $clog2(NDESC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act_req,
  input  logic [IDXW-1:0] act_idx,
  input  logic            chain_go,
  output logic            busy,
  output logic [IDXW-1:0] origin,
  output logic [IDXW-1:0] fetch_idx,
  input  desc_t           fetch_data,
  output logic            eng_we,
  output desc_t           eng_data,
  output logic            wb_fire,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_word,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata
);
  st_t             state;
  desc_t           cur;
  logic [IDXW-1:0] cur_idx;
  logic [IDXW-1:0] next_idx;

  assign next_idx = (cur_idx == IDXW'(NDESC - 1)) ? '0 : cur_idx + IDXW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cur     <= '0;
      cur_idx <= '0;
      origin  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (act_req) begin
          cur_idx <= act_idx;
          origin  <= act_idx;
          state   <= S_FETCH;
        end
        S_FETCH: begin
          cur   <= fetch_data;
          state <= S_RD;
        end
        S_RD: state <= S_WR;
        S_WR: state <= S_WB;
        S_WB: begin
          if (chain_go) begin
            cur_idx <= next_idx;
            state   <= S_FETCH;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign fetch_idx = cur_idx;
  assign wb_fire   = (state == S_WB);
  assign eng_we    = wb_fire;
  assign eng_data  = desc_advance(cur);
  assign mem_req   = (state == S_RD) || (state == S_WR);
  assign mem_we    = (state == S_WR);
  assign mem_word  = cur.mode_a[SZ_BIT];
  assign mem_addr  = (state == S_WR) ? cur.dst : cur.src;
  assign mem_wdata = size_mask(cur.mode_a[SZ_BIT], mem_rdata);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(act_req));
  assert_wr_after_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> $past(mem_req && !mem_we));
  assert_origin_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(origin));
endmodule

// File: rtl/xfer_chain_ctrl.sv
module xfer_chain_ctrl
  import xfc_pkg::*;
#(
  parameter int NDESC = 8,
  localparam int IDXW = $clog2(NDESC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 act_req,
  input  logic [IDXW-1:0]      act_idx,
  output logic                 busy,
  output logic [IDXW-1:0]      done_src,
  output logic                 flag_clr,
  output logic                 en_clr,
  output logic                 cpu_irq,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic                 mem_word,
  output logic [15:0]          mem_addr,
  output logic [15:0]          mem_wdata,
  input  logic [15:0]          mem_rdata,
  input  logic                 cfg_we,
  input  logic [IDXW-1:0]      cfg_idx,
  input  logic [63:0]          cfg_wdata,
  input  logic [IDXW-1:0]      rd_idx,
  output logic [63:0]          rd_data
);
  logic            chain_go;
  logic            wb_fire;
  logic            eng_we;
  desc_t           eng_data;
  desc_t           fetch_data;
  desc_t           rd_desc;
  logic [IDXW-1:0] fetch_idx;
  logic            wb_chain;
  logic            wb_isel;
  logic            wb_zero;

  xfc_desc_mem #(.NDESC(NDESC)) mem_i (
    .clk(clk), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(desc_t'(cfg_wdata)),
    .eng_we(eng_we), .eng_idx(fetch_idx), .eng_data(eng_data),
    .fetch_idx(fetch_idx), .fetch_data(fetch_data),
    .rd_idx(rd_idx), .rd_data(rd_desc)
  );

  xfc_seq #(.NDESC(NDESC)) seq_i (
    .clk(clk), .rst_n(rst_n), .act_req(act_req), .act_idx(act_idx),
    .chain_go(chain_go), .busy(busy), .origin(done_src),
    .fetch_idx(fetch_idx), .fetch_data(fetch_data),
    .eng_we(eng_we), .eng_data(eng_data), .wb_fire(wb_fire),
    .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign wb_chain = eng_data.mode_b[CHAIN_BIT];
  assign wb_isel  = eng_data.mode_b[ISEL_BIT];
  assign wb_zero  = (eng_data.cnt == '0);

  xfc_finish fin_i (
    .clk(clk), .rst_n(rst_n), .wb_fire(wb_fire), .chain(wb_chain),
    .isel(wb_isel), .cnt_zero(wb_zero), .chain_go(chain_go),
    .flag_clr(flag_clr), .en_clr(en_clr), .cpu_irq(cpu_irq)
  );

  assign rd_data = rd_desc;
endmodule

// File: tb/xfer_chain_ctrl_tb.sv
module xfer_chain_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        act_req = 1'b0;
  logic [2:0]  act_idx = '0;
  logic        busy, flag_clr, en_clr, cpu_irq;
  logic [2:0]  done_src;
  logic        mem_req, mem_we, mem_word;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [63:0] cfg_wdata = '0;
  logic [2:0]  rd_idx = '0;
  logic [63:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  xfer_chain_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .act_req(act_req), .act_idx(act_idx),
    .busy(busy), .done_src(done_src), .flag_clr(flag_clr), .en_clr(en_clr),
    .cpu_irq(cpu_irq), .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  function automatic logic [15:0] pat(input logic [15:0] a);
    return {a[7:0] ^ 8'hA5, a[15:8] + a[7:0] + 8'h3C};
  endfunction

  // observation logs
  logic [15:0] lg_ra [0:15];
  logic [15:0] lg_wa [0:15];
  logic [15:0] lg_wd [0:15];
  logic        lg_ww [0:15];
  int n_rd, n_wr, n_fc, n_ec, n_ir, n_busy;
  logic [2:0] lg_src;

  always @(posedge clk) begin
    if (mem_req && !mem_we) begin
      mem_rdata <= pat(mem_addr);
      if (n_rd < 16) lg_ra[n_rd] <= mem_addr;
      n_rd <= n_rd + 1;
    end
    if (mem_req && mem_we) begin
      if (n_wr < 16) begin
        lg_wa[n_wr] <= mem_addr;
        lg_wd[n_wr] <= mem_wdata;
        lg_ww[n_wr] <= mem_word;
      end
      n_wr <= n_wr + 1;
    end
    if (flag_clr) n_fc <= n_fc + 1;
    if (en_clr)   n_ec <= n_ec + 1;
    if (cpu_irq)  n_ir <= n_ir + 1;
    if (flag_clr || en_clr || cpu_irq) lg_src <= done_src;
    if (busy) n_busy <= n_busy + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [63:0] mir [0:7];

  function automatic logic [63:0] mk(input logic [15:0] cnt, input logic [15:0] dst,
                                     input logic [15:0] src, input logic [7:0] mb,
                                     input logic [7:0] ma);
    return {cnt, dst, src, mb, ma};
  endfunction

  task automatic prog(input int idx, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx[2:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    mir[idx] = d;
  endtask

  task automatic run(input int start, input bit poke);
    logic [15:0] e_ra [0:15];
    logic [15:0] e_wa [0:15];
    logic [15:0] e_wd [0:15];
    logic        e_ww [0:15];
    int          seen [0:15];
    int idx, n, e_fc, e_ec, e_ir, guard;
    bit fin;
    logic [63:0] d;
    logic [15:0] sa, da, cn, inc;
    logic wd, sd;
    idx = start; n = 0; fin = 0; e_fc = 0; e_ec = 0; e_ir = 0;
    while (!fin && n < 16) begin
      d  = mir[idx];
      sa = d[31:16]; da = d[47:32]; cn = d[63:48];
      wd = d[0]; sd = d[1];
      e_ra[n] = sa; e_wa[n] = da; e_ww[n] = wd;
      e_wd[n] = wd ? pat(sa) : (pat(sa) & 16'h00FF);
      inc = {14'd0, wd, ~wd};
      if (sd) sa = sa + inc; else da = da + inc;
      cn = cn - 16'd1;
      mir[idx] = {cn, da, sa, d[15:0]};
      seen[n] = idx;
      n++;
      if (d[15]) idx = (idx + 1) % 8;
      else begin
        fin = 1;
        if (cn == 16'd0) begin e_ec = 1; e_ir = 1; end
        else if (d[14]) e_ir = 1;
        else e_fc = 1;
      end
    end
    @(negedge clk);
    n_rd = 0; n_wr = 0; n_fc = 0; n_ec = 0; n_ir = 0; n_busy = 0;
    act_req = 1'b1; act_idx = start[2:0];
    @(negedge clk);
    act_req = 1'b0;
    if (poke) begin
      @(negedge clk);
      act_req = 1'b1; act_idx = start[2:0] + 3'd3;
      @(negedge clk);
      act_req = 1'b0;
    end
    guard = 0;
    while (busy && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    chk(n_busy == 4 * n, "R2 busy cycles", 64'(n_busy), 64'(4 * n));
    chk(n_wr == n && n_rd == n, "R3 transfer count", 64'(n_wr), 64'(n));
    for (int k = 0; k < n && k < 16; k++) begin
      chk(lg_ra[k] == e_ra[k], "R3 read address", 64'(lg_ra[k]), 64'(e_ra[k]));
      chk(lg_wa[k] == e_wa[k], "R4 write address", 64'(lg_wa[k]), 64'(e_wa[k]));
      chk(lg_wd[k] == e_wd[k], "R3 write data", 64'(lg_wd[k]), 64'(e_wd[k]));
      chk(lg_ww[k] == e_ww[k], "R3 size flag", 64'(lg_ww[k]), 64'(e_ww[k]));
    end
    for (int k = 0; k < n && k < 16; k++) begin
      rd_idx = seen[k][2:0];
      #1;
      chk(rd_data == mir[seen[k]], "R5 write-back", rd_data, mir[seen[k]]);
    end
    chk(n_fc == e_fc, "R8 flag_clr pulses", 64'(n_fc), 64'(e_fc));
    chk(n_ec == e_ec, "R7 en_clr pulses", 64'(n_ec), 64'(e_ec));
    chk(n_ir == e_ir, "R9 cpu_irq pulses", 64'(n_ir), 64'(e_ir));
    chk(lg_src == start[2:0], "R11 done_src", 64'(lg_src), 64'(start));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) mir[i] = '0;
    #1;
    chk(!busy && !mem_req, "R1 reset busy/mem", {62'd0, busy, mem_req}, 64'd0);
    chk(!flag_clr && !en_clr && !cpu_irq, "R1 reset pulses", {61'd0, flag_clr, en_clr, cpu_irq}, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) prog(i, mk(16'd9, 16'h0100, 16'h0200, 8'h00, 8'h00));

    // R8: byte, destination advances, count stays nonzero, flag cleared
    prog(2, mk(16'd5, 16'h4000, 16'h1234, 8'h00, 8'h00));
    run(2, 0);
    // R7: word, source advances, count runs out
    prog(3, mk(16'd1, 16'h5000, 16'h2220, 8'h00, 8'h03));
    run(3, 0);
    // R9: interrupt select keeps flag, CPU interrupt passed
    prog(4, mk(16'd3, 16'h6001, 16'h3301, 8'h40, 8'h01));
    run(4, 0);
    // R6: chain 6 -> 7 -> 0 with chained counts reaching zero
    prog(6, mk(16'd1, 16'h7000, 16'h0A00, 8'h80, 8'h01));
    prog(7, mk(16'd1, 16'h7100, 16'h0B00, 8'hC0, 8'h02));
    prog(0, mk(16'd4, 16'h7200, 16'h0C00, 8'h40, 8'h00));
    run(6, 0);
    // R10: all reserved bits set
    prog(5, mk(16'd2, 16'h7F00, 16'h0D10, 8'h3F, 8'hFC));
    run(5, 0);
    prog(1, mk(16'd1, 16'h7E00, 16'h0E11, 8'h3F, 8'hFD));
    run(1, 0);
    // R2: second request during busy is ignored
    prog(2, mk(16'd7, 16'h4800, 16'h1500, 8'h80, 8'h01));
    prog(3, mk(16'd7, 16'h4900, 16'h1600, 8'h00, 8'h00));
    run(2, 1);

    for (int t = 0; t < 40; t++) begin
      int st, len;
      st  = $urandom_range(0, 7);
      len = $urandom_range(1, 3);
      for (int j = 0; j < len; j++) begin
        logic [7:0] ma, mb;
        ma = {6'($urandom), 2'($urandom)};
        mb = {(j != len - 1), 1'($urandom), 6'($urandom)};
        prog((st + j) % 8, mk(16'($urandom_range(1, 4)), 16'($urandom), 16'($urandom), mb, ma));
      end
      run(st, t[2]);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule